// File: doc/BRIEF.md
# Line-Locked Mark Tick Generator

This block paces background work (A/D sample starts and display digit refresh) from the AC mains. It watches a train of shaped line-frequency pulses, measures the line period in system clocks, and spreads eight mark ticks evenly across every line period. Each tick raises a mark interrupt request. The request stays pending until the interrupt controller clears it. Because the period is measured again on every rising line edge, the tick rate follows a drifting mains frequency. Each edge also brings the tick phase back into line.

The period counter is sized for a core clock near 1.7 MHz, where one state lasts about 588 ns. A 50 Hz line gives about 34,000 clocks per period, and the 17-bit counter covers twice that for the loss timeout. The line input must already be synchronous to `clk`. The block also reports whether two successive periods agree, and whether line pulses have stopped.

Top module: `mark_tick_gen`

## Requirements
- R1: With a steady line period of P clocks (P at least 16), exactly eight ticks fall in each period. The first is on the qualified edge. The others fall at elapsed clock c (1..P-1 after the edge) wherever floor(8c/P) rises.
- R2: A rising edge is a cycle in which `line_pulse` is 1 after being 0 in the previous cycle. How long the pulse stays high has no effect on the tick count.
- R3: The first edge after reset or after a loss only starts a measurement and gives no tick. Every later edge stores the measured period and gives a tick.
- R4: Every qualified edge restarts the tick phase. At most seven further ticks follow before the next edge, even if the line slows down.
- R5: `mark_req` goes to 1 the cycle after a tick and holds until `mark_clr` is sampled high with no tick. If a tick and `mark_clr` come in the same cycle, the request stays set.
- R6: On each edge that measures a period, `locked` becomes 1 in the next cycle if the new period is within LOCK_TOL clocks (default 4) of the previously stored one. Otherwise it becomes 0.
- R7: Suppose a period is stored and the elapsed clocks since the last edge reach twice that period with no edge. Then the next cycle shows `line_lost` = 1 and `locked` = 0, and ticks stop. The next rising edge clears `line_lost` and counts as a first edge.
- R8: A synchronous active-high `rst` drives `mark_req`, `locked` and `line_lost` to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_pulse | input | 1 | Shaped line-frequency pulse, synchronous to clk |
| mark_clr | input | 1 | Clears the pending mark request |
| mark_req | output | 1 | Pending mark interrupt request |
| locked | output | 1 | Successive line periods agree within tolerance |
| line_lost | output | 1 | Line pulses have stopped |

## Verification
A tick and its flag updates are decided in the clock edge that samples the rising line edge or the elapsed count. The tick becomes visible on `mark_req`, and a change of `locked` or `line_lost` on its own output, one cycle after that edge. The bench model works out its expected values at each rising clock edge from the same sampled inputs. It compares them against the outputs at the following falling edge, so every result is checked in the exact cycle it is due. Window counts of request cycles, taken with the clear held high, confirm eight ticks per period and the cap on ticks when the line slows.

// File: rtl/mtg_pkg.sv
package mtg_pkg;
    parameter int unsigned CNT_W    = 17;
    parameter int unsigned MUL_LOG2 = 3;
    localparam int unsigned MULT    = 1 << MUL_LOG2;
    localparam int unsigned ACC_W   = CNT_W + 1;

    typedef logic [CNT_W-1:0]    period_t;
    typedef logic [MUL_LOG2-1:0] tick_idx_t;
    typedef logic [ACC_W-1:0]    acc_t;

    // what the period meter tells the tick synthesizer each cycle
    typedef struct packed {
        logic    realign;   // qualified edge: emit tick 0, restart phase
        logic    run;       // a period is stored and still valid
        period_t period;    // last measured period in clocks
    } ref_t;

    function automatic period_t abs_diff(period_t a, period_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic period_t sat_inc(period_t v);
        return (&v) ? v : v + period_t'(1);
    endfunction
endpackage

// File: rtl/mtg_meter.sv
module mtg_meter
    import mtg_pkg::*;
#(
    parameter int unsigned LOCK_TOL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output ref_t ref_o,
    output logic locked,
    output logic lost
);
    logic    line_q;
    logic    seen;
    logic    per_valid;
    period_t cnt;
    period_t period;
    period_t meas;
    logic    edge_w;
    logic    timeout;

    assign edge_w  = line_in & ~line_q;
    assign meas    = sat_inc(cnt);
    assign timeout = per_valid & ~edge_w & ({1'b0, meas} >= {period, 1'b0});

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q    <= 1'b0;
            seen      <= 1'b0;
            per_valid <= 1'b0;
            cnt       <= '0;
            period    <= '0;
            locked    <= 1'b0;
            lost      <= 1'b0;
        end else begin
            line_q <= line_in;
            if (edge_w) begin
                cnt  <= '0;
                seen <= 1'b1;
                lost <= 1'b0;
                if (seen) begin
                    period    <= meas;
                    per_valid <= 1'b1;
                    locked    <= per_valid &&
                                 (abs_diff(meas, period) <= period_t'(LOCK_TOL));
                end
            end else if (timeout) begin
                cnt       <= sat_inc(cnt);
                seen      <= 1'b0;
                per_valid <= 1'b0;
                locked    <= 1'b0;
                lost      <= 1'b1;
            end else begin
                cnt <= sat_inc(cnt);
            end
        end
    end

    always_comb begin
        ref_o.realign = edge_w & seen;
        ref_o.run     = per_valid & ~timeout;
        ref_o.period  = period;
    end

    AST_LOST_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        lost |-> !locked);                                       // R7
    AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(edge_w));                        // R6
endmodule

// File: rtl/mtg_synth.sv
module mtg_synth
    import mtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ref_t ref_i,
    output logic tick
);
    acc_t      acc;
    acc_t      step;
    tick_idx_t ntick;
    logic      room;
    logic      mid_tick;

    assign step     = acc + acc_t'(MULT);
    assign room     = (ntick != tick_idx_t'(MULT - 1));
    assign mid_tick = ref_i.run & room & (step >= {1'b0, ref_i.period});
    assign tick     = ref_i.realign | mid_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            ntick <= '0;
        end else if (ref_i.realign) begin
            acc   <= '0;
            ntick <= '0;
        end else if (mid_tick) begin
            acc   <= step - {1'b0, ref_i.period};
            ntick <= ntick + tick_idx_t'(1);
        end else if (ref_i.run && room) begin
            acc   <= step;
        end
    end

    AST_MID_CAP: assert property (@(posedge clk) disable iff (rst)
        (!room && !ref_i.realign) |-> !tick);                    // R4
    AST_REALIGN_RESTART: assert property (@(posedge clk) disable iff (rst)
        ref_i.realign |=> (ntick == '0));                        // R4
endmodule

// File: rtl/mtg_req_flag.sv
module mtg_req_flag (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clr,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst)       req <= 1'b0;
        else if (tick) req <= 1'b1;
        else if (clr)  req <= 1'b0;
    end
endmodule

// File: rtl/mark_tick_gen.sv
module mark_tick_gen
    import mtg_pkg::*;
#(
    parameter int unsigned LOCK_TOL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_pulse,
    input  logic mark_clr,
    output logic mark_req,
    output logic locked,
    output logic line_lost
);
    ref_t ref_w;
    logic tick;

    mtg_meter #(.LOCK_TOL(LOCK_TOL)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .line_in(line_pulse),
        .ref_o  (ref_w),
        .locked (locked),
        .lost   (line_lost)
    );

    mtg_synth u_synth (
        .clk  (clk),
        .rst  (rst),
        .ref_i(ref_w),
        .tick (tick)
    );

    mtg_req_flag u_flag (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .clr (mark_clr),
        .req (mark_req)
    );

    AST_TICK_SETS_REQ: assert property (@(posedge clk) disable iff (rst)
        tick |=> mark_req);                                      // R5
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mark_req && !mark_clr) |=> mark_req);                   // R5
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (mark_clr && !tick) |=> !mark_req);                      // R5
endmodule

// File: tb/tb_mark_tick_gen.sv
module tb_mark_tick_gen;
    localparam int CLK_PERIOD = 10;
    localparam int TOL        = 4;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_pulse = 1'b0;
    logic mark_clr = 1'b0;
    logic mark_req, locked, line_lost;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int clr_pat = 0;
    bit done = 1'b0;

    mark_tick_gen #(.LOCK_TOL(TOL)) dut (
        .clk(clk), .rst(rst), .line_pulse(line_pulse), .mark_clr(mark_clr),
        .mark_req(mark_req), .locked(locked), .line_lost(line_lost)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int prev_line = 0;
    bit m_seen = 0, m_valid = 0;
    int elapsed = 0, m_period = 0, m_k = 0;
    int exp_req = 0, exp_locked = 0, exp_lost = 0;

    always @(posedge clk) begin
        int is_edge, tk, d;
        if (rst) begin
            prev_line = 0; m_seen = 0; m_valid = 0; elapsed = 0;
            m_period = 0; m_k = 0; exp_req = 0; exp_locked = 0; exp_lost = 0;
        end else begin
            is_edge = (line_pulse && prev_line == 0);
            prev_line = line_pulse;
            tk = 0;
            if (is_edge) begin
                if (m_seen) begin
                    tk = 1;
                    d = (elapsed > m_period) ? elapsed - m_period : m_period - elapsed;
                    exp_locked = (m_valid && d <= TOL);
                    m_period = elapsed;
                    m_valid = 1;
                    m_k = 0;
                end
                m_seen = 1;
                exp_lost = 0;
                elapsed = 1;
            end else begin
                if (m_valid && elapsed >= 2 * m_period) begin
                    exp_lost = 1; exp_locked = 0; m_valid = 0; m_seen = 0;
                end else if (m_valid && m_k < 7 && (8 * elapsed) / m_period > m_k) begin
                    tk = 1;
                    m_k++;
                end
                elapsed++;
            end
            if (tk) exp_req = 1;
            else if (mark_clr) exp_req = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d",
                     req, what, cyc, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(mark_req == exp_req, "R1 R3 R4 R5", "mark_req", mark_req, exp_req);
            chk(locked == exp_locked, "R6", "locked", locked, exp_locked);
            chk(line_lost == exp_lost, "R7", "line_lost", line_lost, exp_lost);
        end
    end

    task automatic drive_clr();
        case (clr_pat)
            0: mark_clr = 1'b1;
            1: mark_clr = (cyc % 7 == 3);
            default: mark_clr = 1'b0;
        endcase
    endtask

    // n line periods of p clocks, pulse high for w; returns request-high
    // cycles seen across the last period
    task automatic pulses(input int p, input int n, input int w, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            for (int c = 0; c < p; c++) begin
                @(negedge clk);
                if (i == n - 1 && mark_req) hits++;
                line_pulse = (c < w);
                drive_clr();
                cyc++;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            line_pulse = 1'b0;
            drive_clr();
            cyc++;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired at cycle %0d: actual=1 expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int h;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(mark_req == 0, "R8", "reset mark_req", mark_req, 0);
        chk(locked == 0, "R8", "reset locked", locked, 0);
        chk(line_lost == 0, "R8", "reset line_lost", line_lost, 0);
        rst = 1'b0;

        // steady line, clear held high: one request cycle per tick
        clr_pat = 0;
        pulses(100, 4, 3, h);
        chk(h == 8, "R1", "ticks in period 100", h, 8);
        chk(locked == 1, "R6", "lock on steady line", locked, 1);

        // odd period, remainder carried
        pulses(137, 3, 5, h);
        chk(h == 8, "R1", "ticks in period 137", h, 8);
        chk(locked == 1, "R6", "relock at 137", locked, 1);

        // wide pulse counts once
        pulses(100, 3, 60, h);
        chk(h == 8, "R2", "ticks with wide pulse", h, 8);

        // small drift stays locked, jump unlocks
        pulses(102, 1, 2, h);
        pulses(104, 2, 2, h);
        chk(locked == 1, "R6", "lock across drift", locked, 1);
        pulses(130, 2, 2, h);
        chk(locked == 0, "R6", "unlock on jump", locked, 0);

        // line slows: stored 100, actual 180 -> capped at eight
        pulses(100, 2, 2, h);
        pulses(180, 1, 2, h);
        chk(h == 8, "R4", "tick cap on slow line", h, 8);

        // pulses stop: loss after twice the stored period
        idle(100);
        chk(line_lost == 1, "R7", "loss flag", line_lost, 1);
        chk(locked == 0, "R7", "unlock on loss", locked, 0);

        // resume with no clears: first edge gives no tick, clears loss
        clr_pat = 2;
        idle(1);
        pulses(120, 1, 2, h);
        chk(h == 0, "R3", "no tick after first edge", h, 0);
        chk(line_lost == 0, "R7", "loss cleared by edge", line_lost, 0);
        pulses(120, 2, 2, h);
        chk(mark_req == 1, "R5", "request held without clear", mark_req, 1);

        // sparse clears, collisions with ticks
        clr_pat = 1;
        pulses(120, 3, 2, h);
        idle(1);

        // reset mid-run
        rst = 1'b1;
        @(negedge clk);
        chk(mark_req == 0, "R8", "mid-run reset mark_req", mark_req, 0);
        chk(locked == 0, "R8", "mid-run reset locked", locked, 0);
        rst = 1'b0;
        pulses(110, 3, 2, h);
        idle(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule